// File: doc/BRIEF.md
# Infrared Receive Interval Timer

This block times the gaps between edges on an infrared receive line. A 16-bit counter advances on one of two tick sources: a general timer-clock enable or a carrier-cycle tick. The receive line is first synchronized. Edges on the synchronized level are then screened by a programmable edge filter. An edge that passes the filter is a qualified edge, and only qualified edges act on the block.

The block has two receive modes. In capture mode, each qualified edge does three things: it latches the new line level, it copies the running count into the capture register, and it raises the event flag. In burst-count mode, the capture register instead counts the qualified edges within a carrier burst. The event flag then marks the start of a space, meaning the carrier has been absent for two carrier ticks.

A counter wrap raises a separate overflow flag. Both flags are sticky and are cleared by a one-cycle clear pulse. An interrupt request combines each flag with its enable. Edge events are not a data stream: the results sit in plain registers, and software reads them whenever it chooses. There is no back-pressure, and a new qualified edge simply overwrites the previous capture.

Top module: `ir_rx_timer`

## Requirements
- R1: In capture mode (`ctl_burst`=0), a qualified edge copies the count held just before that edge into `capture_o` and sets `evt_flag`.
- R2: A qualified edge loads `data_o` with the new line level: 0 after a falling edge, 1 after a rising edge.
- R3: With `ctl_reload`=1, a qualified edge clears the count to 0. With `ctl_reload`=0, the count keeps running.
- R4: `ctl_edge_sel` sets which edges qualify: 2'b00 falling only, 2'b01 rising only, 2'b10 both, 2'b11 none. Edges that do not qualify leave `capture_o`, `data_o` and `evt_flag` unchanged.
- R5: When a selected tick moves the count from 16'hFFFF to 0, `ovf_flag` is set. This does not happen if a reloading qualified edge occurs in that same cycle.
- R6: While the block is inactive (`ctl_enable`=0 or `ctl_tx_mode`=1), the count is held at 0 and edges have no effect.
- R7: When `ctl_burst` goes from 0 to 1, `capture_o` is loaded with 1. After that, each qualified edge adds 1 to `capture_o`, the count is not captured, and edges do not set `evt_flag`.
- R8: `ctl_src_carrier`=0 makes the count advance on `tick_clk`. `ctl_src_carrier`=1 makes it advance on `tick_carrier`. The unselected tick has no effect.
- R9: Each flag stays set until its clear input is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R10: In burst-count mode, `evt_flag` is set on the second `tick_carrier` with no qualified edge since the last one. A qualified edge restarts this tick count.
- R11: `irq` is high whenever (`ovf_flag` and `ie_ovf`) or (`evt_flag` and `ie_evt`).
- R12: After reset, all outputs are 0. A change on `rx_pin` takes effect on the registers three clock edges later: two synchronizer stages, then the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Infrared receive line (asynchronous) |
| tick_clk | input | 1 | Timer-clock enable |
| tick_carrier | input | 1 | Carrier-cycle tick |
| ctl_enable | input | 1 | Module enable |
| ctl_tx_mode | input | 1 | 1 selects transmit, which makes the receive side inactive |
| ctl_burst | input | 1 | Burst-count mode select |
| ctl_edge_sel | input | 2 | Qualified edge select (see R4) |
| ctl_reload | input | 1 | Clear the count on a qualified edge |
| ctl_src_carrier | input | 1 | Count tick source select |
| ie_ovf | input | 1 | Overflow interrupt enable |
| ie_evt | input | 1 | Event interrupt enable |
| clr_ovf | input | 1 | Clear pulse for the overflow flag |
| clr_evt | input | 1 | Clear pulse for the event flag |
| count_o | output | 16 | Running interval count |
| capture_o | output | 16 | Captured count or burst edge count |
| data_o | output | 1 | Line level captured at the last qualified edge |
| ovf_flag | output | 1 | Sticky overflow flag |
| evt_flag | output | 1 | Sticky capture / carrier-absent flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth or a wrong edge polarity shows up on `capture_o` and `data_o` exactly three cycles after the line changes, so every edge check samples at that cycle. A count that fails to clear, or that uses the wrong tick source, is visible on `count_o` on the next edge and then spreads into the following capture. The quiet-tick counter in burst-count mode is internal. If it is wrong, `evt_flag` rises one carrier tick too early or too late, or a qualified edge fails to restart it. This is checked by placing edges between carrier ticks. A wrap that is missed appears only after 65536 ticks, so the bench drives one complete wrap.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ir_rx_edge_detect.sv
module ir_rx_edge_detect
  import ir_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_pin,
  input  logic      active,
  input  edge_sel_e sel,
  output logic      level,
  output logic      qual
);
  // Synchronizer stages followed by one history bit for edge detection.
  logic [SYNC_STAGES:0] chain;
  logic prev, rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[SYNC_STAGES-1:0], rx_pin};
  end

  assign level = chain[SYNC_STAGES-1];
  assign prev  = chain[SYNC_STAGES];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

  always_comb begin
    unique case (sel)
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      EDGE_NONE: hit = 1'b0;
    endcase
  end

  assign qual = active & hit;
endmodule

// File: rtl/ir_rx_interval_counter.sv
module ir_rx_interval_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!active) count <= '0;
    else if (clear)   count <= '0;
    else if (tick)    count <= count + 1'b1;
  end

  assign wrap = active & ~clear & tick & (count == '1);
endmodule

// File: rtl/ir_rx_capture_unit.sv
module ir_rx_capture_unit #(
  parameter int CNT_W        = 16,
  parameter int ABSENT_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             burst,
  input  logic             qual,
  input  logic             level,
  input  logic             carrier_tick,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             data,
  output logic             evt_set
);
  localparam int QW = $clog2(ABSENT_TICKS + 1);
  localparam logic [QW-1:0] QUIET_LAST = QW'(ABSENT_TICKS - 1);
  localparam logic [QW-1:0] QUIET_MAX  = QW'(ABSENT_TICKS);

  logic          burst_d, burst_enter, absent_hit;
  logic [QW-1:0] quiet;

  assign burst_enter = burst & ~burst_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_d <= 1'b0;
    else        burst_d <= burst;
  end

  // Carrier ticks seen since the last qualified edge, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              quiet <= '0;
    else if (!active || !burst || qual)      quiet <= '0;
    else if (carrier_tick && quiet != QUIET_MAX) quiet <= quiet + 1'b1;
  end

  assign absent_hit = active & burst & ~qual & carrier_tick & (quiet == QUIET_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           capture <= '0;
    else if (burst_enter) capture <= CNT_W'(1);
    else if (qual)        capture <= burst ? capture + 1'b1 : count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data <= 1'b0;
    else if (qual) data <= level;
  end

  assign evt_set = (qual & ~burst) | absent_hit;
endmodule

// File: rtl/ir_rx_timer.sv
module ir_rx_timer
  import ir_rx_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int ABSENT_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_pin,
  input  logic             tick_clk,
  input  logic             tick_carrier,
  input  logic             ctl_enable,
  input  logic             ctl_tx_mode,
  input  logic             ctl_burst,
  input  logic [1:0]       ctl_edge_sel,
  input  logic             ctl_reload,
  input  logic             ctl_src_carrier,
  input  logic             ie_ovf,
  input  logic             ie_evt,
  input  logic             clr_ovf,
  input  logic             clr_evt,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             data_o,
  output logic             ovf_flag,
  output logic             evt_flag,
  output logic             irq
);
  logic active, edge_qual, sync_level, sel_tick, wrap, evt_set;

  assign active   = ctl_enable & ~ctl_tx_mode;
  assign sel_tick = ctl_src_carrier ? tick_carrier : tick_clk;

  ir_rx_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_pin (rx_pin),
    .active (active),
    .sel    (edge_sel_e'(ctl_edge_sel)),
    .level  (sync_level),
    .qual   (edge_qual)
  );

  ir_rx_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .tick   (sel_tick),
    .clear  (edge_qual & ctl_reload),
    .count  (count_o),
    .wrap   (wrap)
  );

  ir_rx_capture_unit #(.CNT_W(CNT_W), .ABSENT_TICKS(ABSENT_TICKS)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .burst        (ctl_burst),
    .qual         (edge_qual),
    .level        (sync_level),
    .carrier_tick (tick_carrier),
    .count        (count_o),
    .capture      (capture_o),
    .data         (data_o),
    .evt_set      (evt_set)
  );

  // Sticky flags: a set in the same cycle as a clear takes priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      ovf_flag <= (ovf_flag & ~clr_ovf) | wrap;
      evt_flag <= (evt_flag & ~clr_evt) | evt_set;
    end
  end

  assign irq = (ovf_flag & ie_ovf) | (evt_flag & ie_evt);
endmodule

// File: rtl/ir_rx_timer_checker.sv
module ir_rx_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_enable,
  input logic             ctl_tx_mode,
  input logic             ctl_burst,
  input logic             ctl_reload,
  input logic             ctl_src_carrier,
  input logic             tick_clk,
  input logic             tick_carrier,
  input logic             clr_ovf,
  input logic             clr_evt,
  input logic             edge_qual,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] capture_o,
  input logic             ovf_flag,
  input logic             evt_flag
);
  logic run, step, burst_seen;
  assign run  = ctl_enable & ~ctl_tx_mode;
  assign step = ctl_src_carrier ? tick_carrier : tick_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_seen <= 1'b0;
    else        burst_seen <= ctl_burst;
  end

  assert_capture_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctl_burst && edge_qual) |=> (capture_o == $past(count_o)) && evt_flag);

  assert_ovf_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && (count_o == {CNT_W{1'b1}}) && !(edge_qual && ctl_reload)) |=> ovf_flag);

  assert_idle_count_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_o == '0));

  assert_burst_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_burst && !burst_seen) |=> (capture_o == CNT_W'(1)));

  assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctl_burst && burst_seen && edge_qual) |=> (capture_o == $past(capture_o) + 1'b1));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  assert_evt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !clr_evt) |=> evt_flag);
endmodule

bind ir_rx_timer ir_rx_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ctl_enable      (ctl_enable),
  .ctl_tx_mode     (ctl_tx_mode),
  .ctl_burst       (ctl_burst),
  .ctl_reload      (ctl_reload),
  .ctl_src_carrier (ctl_src_carrier),
  .tick_clk        (tick_clk),
  .tick_carrier    (tick_carrier),
  .clr_ovf         (clr_ovf),
  .clr_evt         (clr_evt),
  .edge_qual       (edge_qual),
  .count_o         (count_o),
  .capture_o       (capture_o),
  .ovf_flag        (ovf_flag),
  .evt_flag        (evt_flag)
);

// File: tb/ir_rx_timer_test.sv
module ir_rx_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_pin = 1'b1, tick_clk = 1'b0, tick_carrier = 1'b0;
  logic        ctl_enable = 1'b1, ctl_tx_mode = 1'b0, ctl_burst = 1'b0;
  logic [1:0]  ctl_edge_sel = 2'b00;
  logic        ctl_reload = 1'b1, ctl_src_carrier = 1'b0;
  logic        ie_ovf = 1'b1, ie_evt = 1'b0, clr_ovf = 1'b0, clr_evt = 1'b0;
  logic [15:0] count_o, capture_o;
  logic        data_o, ovf_flag, evt_flag, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ir_rx_timer uut (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tick_clk(tick_clk),
    .tick_carrier(tick_carrier), .ctl_enable(ctl_enable), .ctl_tx_mode(ctl_tx_mode),
    .ctl_burst(ctl_burst), .ctl_edge_sel(ctl_edge_sel), .ctl_reload(ctl_reload),
    .ctl_src_carrier(ctl_src_carrier), .ie_ovf(ie_ovf), .ie_evt(ie_evt),
    .clr_ovf(clr_ovf), .clr_evt(clr_evt), .count_o(count_o), .capture_o(capture_o),
    .data_o(data_o), .ovf_flag(ovf_flag), .evt_flag(evt_flag), .irq(irq)
  );

  typedef struct {
    string       tag;
    logic [15:0] cnt;
    logic [15:0] cap;
    logic        dat;
    logic        ovf;
    logic        evt;
    logic        irq;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;

  // Expected state, set by the sequence from the requirements.
  logic [15:0] e_cnt = 0, e_cap = 0;
  logic        e_dat = 0, e_ovf = 0, e_evt = 0;

  task automatic expect_state(input string tag);
    exp_t it;
    it.tag = tag; it.cnt = e_cnt; it.cap = e_cap; it.dat = e_dat;
    it.ovf = e_ovf; it.evt = e_evt;
    it.irq = (e_ovf & ie_ovf) | (e_evt & ie_evt);
    sb_q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        cmp(it.tag, "count_o",   count_o,          it.cnt);
        cmp(it.tag, "capture_o", capture_o,        it.cap);
        cmp(it.tag, "data_o",    {15'd0, data_o},  {15'd0, it.dat});
        cmp(it.tag, "ovf_flag",  {15'd0, ovf_flag},{15'd0, it.ovf});
        cmp(it.tag, "evt_flag",  {15'd0, evt_flag},{15'd0, it.evt});
        cmp(it.tag, "irq",       {15'd0, irq},     {15'd0, it.irq});
      end
    end
  end

  task automatic ticks(input int n);
    @(negedge clk) tick_clk = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) tick_clk = 1'b0;
  endtask

  task automatic carrier(input int n);
    @(negedge clk) tick_carrier = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) tick_carrier = 1'b0;
  endtask

  task automatic line_to(input logic v);
    @(negedge clk) rx_pin = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_evt;
    @(negedge clk) clr_evt = 1'b1;
    @(posedge clk);
    @(negedge clk) clr_evt = 1'b0;
    e_evt = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    expect_state("R12 reset");

    // Capture mode, falling edges, reload on.
    ticks(5); e_cnt = 5;
    line_to(1'b0); e_cap = 5; e_dat = 0; e_evt = 1; e_cnt = 0;
    expect_state("R1 R2 R3 capture with reload");
    repeat (4) @(negedge clk);
    expect_state("R9 event flag sticky");
    clear_evt();
    expect_state("R9 event flag cleared");

    ticks(7); e_cnt = 7;
    line_to(1'b1);
    expect_state("R4 rising ignored with select 00");

    @(negedge clk) ctl_edge_sel = 2'b01;
    ticks(2); e_cnt = 9;
    line_to(1'b0);
    expect_state("R4 falling ignored with select 01");
    line_to(1'b1); e_cap = 9; e_dat = 1; e_evt = 1; e_cnt = 0;
    expect_state("R4 R2 rising captured with select 01");
    clear_evt();

    @(negedge clk) ctl_edge_sel = 2'b10;
    ticks(3); e_cnt = 3;
    line_to(1'b0); e_cap = 3; e_dat = 0; e_evt = 1; e_cnt = 0;
    expect_state("R4 both edges select");
    clear_evt();

    @(negedge clk) ctl_reload = 1'b0;
    ticks(4); e_cnt = 4;
    line_to(1'b1); e_cap = 4; e_dat = 1; e_evt = 1;
    expect_state("R3 no reload keeps count");
    clear_evt();

    @(negedge clk) ctl_edge_sel = 2'b11;
    line_to(1'b0);
    expect_state("R4 no edges with select 11");

    // Overflow: count is 4, drive to FFFF then wrap.
    ticks(65531); e_cnt = 16'hFFFF;
    expect_state("R5 at top no overflow yet");
    ticks(1); e_cnt = 0; e_ovf = 1;
    expect_state("R5 R11 wrap sets overflow and irq");
    @(negedge clk) clr_ovf = 1'b1;
    @(posedge clk);
    @(negedge clk) clr_ovf = 1'b0; e_ovf = 0;
    expect_state("R9 overflow cleared");

    // Tick source select.
    @(negedge clk) ctl_src_carrier = 1'b1;
    ticks(3);
    expect_state("R8 timer tick ignored on carrier source");
    carrier(2); e_cnt = 2;
    expect_state("R8 carrier ticks counted");
    @(negedge clk) ctl_src_carrier = 1'b0;

    // Inactive: disabled, then transmit mode.
    @(negedge clk) begin ctl_edge_sel = 2'b10; ctl_enable = 1'b0; end
    @(negedge clk); e_cnt = 0;
    ticks(3);
    line_to(1'b1);
    expect_state("R6 disabled holds count and ignores edge");
    @(negedge clk) begin ctl_enable = 1'b1; ctl_tx_mode = 1'b1; end
    ticks(2);
    line_to(1'b0);
    expect_state("R6 transmit mode ignores edge");
    @(negedge clk) ctl_tx_mode = 1'b0;

    // Burst-count mode.
    @(negedge clk) begin ie_evt = 1'b1; ctl_burst = 1'b1; end
    @(posedge clk);
    @(negedge clk); e_cap = 1;
    expect_state("R7 burst entry loads one");
    ticks(6); e_cnt = 6;
    line_to(1'b1); e_cap = 2; e_dat = 1;
    expect_state("R7 R2 burst edge counted, no capture");
    line_to(1'b0); e_cap = 3; e_dat = 0;
    expect_state("R7 burst second edge");
    carrier(1);
    expect_state("R10 one quiet carrier tick");
    carrier(1); e_evt = 1;
    expect_state("R10 R11 two quiet ticks flag space");
    clear_evt();
    line_to(1'b1); e_cap = 4; e_dat = 1;
    carrier(1);
    line_to(1'b0); e_cap = 5; e_dat = 0;
    carrier(1);
    expect_state("R10 edge restarts quiet count");
    carrier(1); e_evt = 1;
    expect_state("R10 space after restart");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule